// File: doc/BRIEF.md
# Modem Control and Status Block for a 16550-Style Serial Port

This block keeps the modem-side state of a 16550-compatible serial port. Four handshake inputs from the line (clear-to-send, data-set-ready, carrier detect and ring indicator) pass through a synchronizer. Their settled levels are held in the upper half of an 8-bit status register. The lower half of that register holds sticky change flags. The block also holds the 5-bit modem control register, which drives the request-to-send, data-terminal-ready and two general-purpose outputs. The host reads the status register through a read strobe that clears the change flags. It writes the control register through a write strobe.

A loopback mode is selected by bit 4 of the control register. In loopback, the four outputs are forced low and the line inputs are no longer observed. A status read then returns the control bits remapped onto the status level positions. The block raises a modem interrupt request whenever the interrupt enable is set and any change flag is pending. The interrupt prioritizer that combines this request with other sources sits outside the block.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset the status read returns 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags), the control read returns 0x08, only `out2_o` is high, and `modem_irq` is low.
- R2: Status bits 7..4 show carrier, ring, data-set-ready and clear-to-send in that order. A line change appears on them at the third rising clock edge after it is applied (two synchronizer stages plus the status register), and not before.
- R3: When a settled line level changes, the change flag for that line is set, in either direction, for clear-to-send (bit 0), data-set-ready (bit 1) and carrier (bit 3). Flags already set stay set until a read clears them.
- R4: Status bit 2 is set only when ring goes from 1 to 0. A rising ring leaves bit 2 clear.
- R5: A cycle with `msr_rd` high outside loopback shows the status value on `msr_rdata` and clears bits 3..0 at that clock edge. Bits 7..4 are not affected.
- R6: A change event that lands on the same edge as a clearing read sets its flag, while the other flags are cleared.
- R7: A control write stores `mcr_wdata[4:0]`, and the control read returns zero in bits 7..5. Outside loopback, the outputs follow the stored bits one edge after the write: `dtr_o` from bit 0, `rts_o` from bit 1, `out1_o` from bit 2 and `out2_o` from bit 3.
- R8: With control bit 4 set, all four outputs are low. A status read returns control bit 3 on bit 7, bit 2 on bit 6, bit 0 on bit 5 and bit 1 on bit 4, and zero on bits 3..0.
- R9: In loopback the line inputs are ignored. The held levels and the change flags do not change, and a read does not clear the flags. After loopback ends, any difference between the lines and the held levels raises flags on the following edge.
- R10: `modem_irq` is a register that is high exactly when `msi_en` was high at the previous edge and a change flag is pending after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcr_wr | input | 1 | Control register write strobe |
| mcr_wdata | input | 8 | Control write data; bits 7..5 are dropped |
| msr_rd | input | 1 | Status read strobe; clears change flags outside loopback |
| msi_en | input | 1 | Modem interrupt enable from the interrupt enable register |
| line_cts | input | 1 | Clear-to-send line, asynchronous, active high |
| line_dsr | input | 1 | Data-set-ready line, asynchronous, active high |
| line_dcd | input | 1 | Carrier detect line, asynchronous, active high |
| line_ri | input | 1 | Ring indicator line, asynchronous, active high |
| msr_rdata | output | 8 | Status register view |
| mcr_rdata | output | 8 | Control register view |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| modem_irq | output | 1 | Modem status interrupt request |

## Verification
The bench sweeps every pair of old and new line nibbles. A design that treated ring like the other lines would set bit 2 on a rising ring. A design one synchronizer stage short would show the new level one edge early. The bench places a line change on the same edge as a clearing read: a design that cleared after merging the events would lose the fresh flag. The bench sweeps all control combinations in loopback, which exposes a swapped mapping or live outputs. It also reads in loopback and then leaves loopback, which catches a design that cleared flags or tracked the lines while looped back.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int LINES  = 4;
  localparam int CTRL_W = 5;
  localparam int DATA_W = 8;

  // line nibble order, also the bit order inside each status half
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  // control register bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  localparam logic [LINES-1:0]  LINES_RST = 4'b1011;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 5'b01000;

  // control outputs seen as line levels while looped back
  function automatic logic [LINES-1:0] loop_levels(input logic [CTRL_W-1:0] c);
    logic [LINES-1:0] m;
    m[L_CTS] = c[C_RTS];
    m[L_DSR] = c[C_DTR];
    m[L_RI]  = c[C_OUT1];
    m[L_DCD] = c[C_OUT2];
    return m;
  endfunction
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else if (g == 0) stage_q[g] <= d;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta
  import modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lvl_in,
  input  logic             freeze,
  input  logic             clr,
  output logic [LINES-1:0] stat_q,
  output logic [LINES-1:0] dlt_q,
  output logic [LINES-1:0] dlt_nx
);
  logic [LINES-1:0] diff;
  logic [LINES-1:0] evt;
  logic [LINES-1:0] stat_nx;

  always_comb begin
    diff = freeze ? '0 : (lvl_in ^ stat_q);
    evt  = diff;
    // ring flag only on a falling edge
    evt[L_RI] = diff[L_RI] & stat_q[L_RI];
    dlt_nx  = (clr ? '0 : dlt_q) | evt;
    stat_nx = freeze ? stat_q : lvl_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= LINES_RST;
      dlt_q  <= '0;
    end else begin
      stat_q <= stat_nx;
      dlt_q  <= dlt_nx;
    end
  end

  a_r4_ring_rise_no_flag: assert property (@(posedge clk) disable iff (rst)
    (!freeze && !stat_q[L_RI] && lvl_in[L_RI] && !dlt_q[L_RI]) |=> !dlt_q[L_RI]);
  a_r6_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (!freeze && (lvl_in[L_CTS] != stat_q[L_CTS])) |=> dlt_q[L_CTS]);
  a_r5_quiet_read_clears: assert property (@(posedge clk) disable iff (rst)
    (clr && !freeze && (lvl_in == stat_q)) |=> (dlt_q == '0));
  a_r9_frozen_levels: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(stat_q));
  a_r9_frozen_flags: assert property (@(posedge clk) disable iff (rst)
    freeze |=> (dlt_q == $past(dlt_q)));
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [LINES-1:0]  pins_q
);
  logic [CTRL_W-1:0] ctrl_nx;

  always_comb begin
    ctrl_nx = wr_en ? wr_data[CTRL_W-1:0] : ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      pins_q <= CTRL_RST[LINES-1:0];
    end else begin
      ctrl_q <= ctrl_nx;
      pins_q <= ctrl_nx[C_LOOP] ? '0 : ctrl_nx[LINES-1:0];
    end
  end

  a_r8_loop_pins_low: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[C_LOOP] |-> (pins_q == '0));
  a_r7_pins_follow: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[C_LOOP] |-> (pins_q == ctrl_q[LINES-1:0]));
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mcr_wr,
  input  logic [7:0] mcr_wdata,
  input  logic       msr_rd,
  input  logic       msi_en,
  input  logic       line_cts,
  input  logic       line_dsr,
  input  logic       line_dcd,
  input  logic       line_ri,
  output logic [7:0] msr_rdata,
  output logic [7:0] mcr_rdata,
  output logic       rts_o,
  output logic       dtr_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       modem_irq
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [LINES-1:0]  raw_lines;
  logic [LINES-1:0]  sync_lines;
  logic [LINES-1:0]  stat_q;
  logic [LINES-1:0]  dlt_q;
  logic [LINES-1:0]  dlt_nx;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LINES-1:0]  pins_q;
  logic              looped;
  logic              irq_q;

  always_comb begin
    raw_lines        = '0;
    raw_lines[L_CTS] = line_cts;
    raw_lines[L_DSR] = line_dsr;
    raw_lines[L_RI]  = line_ri;
    raw_lines[L_DCD] = line_dcd;
  end

  modem_sync #(
    .WIDTH  (LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINES_RST)
  ) sync_i (
    .clk(clk),
    .rst(rst),
    .d  (raw_lines),
    .q  (sync_lines)
  );

  modem_ctrl_reg ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (mcr_wr),
    .wr_data(mcr_wdata),
    .ctrl_q (ctrl_q),
    .pins_q (pins_q)
  );

  assign looped = ctrl_q[C_LOOP];

  modem_delta delta_i (
    .clk   (clk),
    .rst   (rst),
    .lvl_in(sync_lines),
    .freeze(looped),
    .clr   (msr_rd & ~looped),
    .stat_q(stat_q),
    .dlt_q (dlt_q),
    .dlt_nx(dlt_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= msi_en & (|dlt_nx);
  end

  always_comb begin
    if (looped) msr_rdata = {loop_levels(ctrl_q), {LINES{1'b0}}};
    else        msr_rdata = {stat_q, dlt_q};
  end

  assign mcr_rdata = {{PAD_W{1'b0}}, ctrl_q};
  assign dtr_o     = pins_q[C_DTR];
  assign rts_o     = pins_q[C_RTS];
  assign out1_o    = pins_q[C_OUT1];
  assign out2_o    = pins_q[C_OUT2];
  assign modem_irq = irq_q;

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    modem_irq |-> (dlt_q != '0));
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !$past(msi_en) |-> !modem_irq);
  a_r7_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
    mcr_rdata[7:5] == 3'b000);
endmodule

// File: tb/modem_ctl_status_tb_top.sv
module modem_ctl_status_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       mcr_wr, msr_rd, msi_en;
  logic [7:0] mcr_wdata;
  logic       line_cts, line_dsr, line_dcd, line_ri;
  logic [7:0] msr_rdata, mcr_rdata;
  logic       rts_o, dtr_o, out1_o, out2_o, modem_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  modem_ctl_status dut_i (
    .clk(clk), .rst(rst), .mcr_wr(mcr_wr), .mcr_wdata(mcr_wdata),
    .msr_rd(msr_rd), .msi_en(msi_en),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_dcd(line_dcd), .line_ri(line_ri),
    .msr_rdata(msr_rdata), .mcr_rdata(mcr_rdata),
    .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o),
    .modem_irq(modem_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nibble order: [3]=carrier [2]=ring [1]=dsr [0]=cts
  task automatic set_lines(input logic [3:0] n);
    {line_dcd, line_ri, line_dsr, line_cts} = n;
  endtask

  task automatic read_pulse();
    msr_rd = 1'b1;
    step(1);
    msr_rd = 1'b0;
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    mcr_wdata = v;
    mcr_wr = 1'b1;
    step(1);
    mcr_wr = 1'b0;
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, out2_o, out1_o, rts_o, dtr_o};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; mcr_wr = 0; msr_rd = 0; msi_en = 0; mcr_wdata = 0;
    set_lines(4'b1011);
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    check("R1 msr", msr_rdata, 8'hB0);
    check("R1 mcr", mcr_rdata, 8'h08);
    check("R1 pins", pins(), 8'h08);
    check("R1 irq", {7'b0, modem_irq}, 8'h00);

    // R2 R3 R4 R5 R10: sweep every old/new nibble pair
    msi_en = 1'b1;
    for (int f = 0; f < 16; f++) begin
      for (int t = 0; t < 16; t++) begin
        logic [3:0] fr, to, d, el;
        fr = f[3:0]; to = t[3:0];
        set_lines(fr);
        step(4);
        read_pulse();
        check("R5 cleared", msr_rdata, {fr, 4'b0});
        check("R10 irq off", {7'b0, modem_irq}, 8'h00);
        set_lines(to);
        step(2);
        check("R2 latency", {4'b0, msr_rdata[7:4]}, {4'b0, fr});
        step(1);
        d  = fr ^ to;
        el = {d[3], fr[2] & ~to[2], d[1], d[0]};
        check("R3 R4 flags", msr_rdata, {to, el});
        check("R10 irq", {7'b0, modem_irq}, {7'b0, el != 4'b0});
        step(2);
        check("R3 sticky", {4'b0, msr_rdata[3:0]}, {4'b0, el});
      end
    end

    // R6: fresh event on the clearing edge survives; older flag cleared
    set_lines(4'b1011); step(4); read_pulse();
    set_lines(4'b1001); step(3);           // dsr falls -> flag bit 1
    check("R6 setup", msr_rdata, 8'h92);
    set_lines(4'b1000); step(2);           // cts falls, lands on next edge
    msr_rd = 1'b1; step(1); msr_rd = 1'b0;
    check("R6 survive", msr_rdata, 8'h81);

    // R10 mask: flags pending but enable low
    msi_en = 1'b0; step(1);
    check("R10 masked", {7'b0, modem_irq}, 8'h00);
    msi_en = 1'b1; step(1);
    check("R10 enabled", {7'b0, modem_irq}, 8'h01);
    read_pulse();

    // R7: upper bits dropped, outputs follow
    write_ctrl(8'hEB);
    check("R7 mcr", mcr_rdata, 8'h0B);
    check("R7 pins", pins(), 8'h0B);
    for (int c = 0; c < 16; c++) begin
      write_ctrl(c[7:0]);
      check("R7 sweep pins", pins(), c[7:0]);
    end

    // R8: loopback mapping over all control values
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cb;
      cb = c[3:0];
      write_ctrl({3'b0, 1'b1, cb});
      check("R8 pins low", pins(), 8'h00);
      check("R8 map", msr_rdata, {cb[3], cb[2], cb[0], cb[1], 4'b0});
      check("R8 mcr", mcr_rdata, {3'b0, 1'b1, cb});
    end

    // R9: lines ignored in loopback, read does not clear, catch-up after exit
    write_ctrl(8'h00);
    set_lines(4'b1011); step(4); read_pulse();
    set_lines(4'b1010); step(3);           // cts falls -> flag bit 0
    check("R9 setup", msr_rdata, 8'hA1);
    write_ctrl(8'h10);
    set_lines(4'b1000); step(4);           // dsr falls while looped
    read_pulse();
    check("R9 irq held", {7'b0, modem_irq}, 8'h01);
    write_ctrl(8'h00);
    check("R9 frozen", msr_rdata, 8'hA1);
    step(1);
    check("R9 catch-up", msr_rdata, 8'h83);

    finish_run();
  end
endmodule